// File: doc/BRIEF.md
# Retiming Decision Stage with Dual Phase Comparison

This block retimes a serial NRZ data stream and reports where the sampling edge falls inside the data eye. The whole design runs on one oversampling clock. A bit-clock enable marks the sampling instant, and the data input carries one sample per oversample tick. The incoming sample first passes through a short register delay line. It then enters a pair of retiming flops that load only on the bit-clock enable. The first flop drives the retimed data output.

Two XOR comparisons are formed. The lead comparison sets the delayed input against the first flop. How long it stays high after each data edge grows with the distance from the data edge to the sampling instant. The density comparison sets the first flop against the second. It is high for exactly one bit period after every retimed transition, so its average follows transition density alone. Two tick counters integrate each comparison over a programmable number of bit periods. At the close of each window they latch their totals and raise a one-cycle valid pulse. A signed error, twice the lead total minus the density total, is near zero when the edge sits in the eye centre. It is negative when sampling is early and positive when sampling is late.

Top module: `retime_phase_mon`

## Requirements
- R1: On a clock edge where `bit_en` is high, `rdata` takes the value `din` carried DLY_STAGES clock edges before that edge (default DLY_STAGES = 2).
- R2: On a clock edge where `bit_en` is low, `rdata` keeps its value.
- R3: On a clock edge where `bit_en` is high, the second retiming flop loads the value `rdata` held just before that edge.
- R4: `cmp_lead` is high exactly when the delayed input sample (the delay line output) differs from `rdata`.
- R5: `cmp_dens` is high exactly when `rdata` differs from the second retiming flop, so after each `bit_en` edge it shows whether `rdata` changed on that edge.
- R6: A window spans `win_bits` bit-enable ticks, and a value of 0 is taken as 1. At the clock edge carrying the last bit-enable tick of a window, `cnt_lead` and `cnt_dens` latch how many clock edges of that window, the closing edge included, saw `cmp_lead` or `cmp_dens` high. Counting then restarts from zero.
- R7: `res_valid` is high for the one cycle after each window-closing edge and low otherwise. `cnt_lead` and `cnt_dens` change only in cycles where `res_valid` is high.
- R8: `phase_err` equals 2*`cnt_lead` - `cnt_dens` as a signed two's complement value of width CNT_W+2.
- R9: Each window total saturates at 2^CNT_W - 1 and does not wrap.
- R10: A synchronous active-high `rst` clears the delay line, both retiming flops, the window counters, both latched totals and `res_valid`.
- R11: Take data that changes only at bit boundaries, OSR ticks per bit, with `bit_en` at tick offset k after each boundary (2 <= k < OSR). Each transition then adds k-1 ticks to the lead total and OSR ticks to the density total. So `phase_err` is negative for k below the centre offset (OSR/2+1), within ±OSR of zero at the centre, and positive above it. `cnt_dens` is a multiple of OSR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable, high on the sampling tick |
| din | input | 1 | Serial data, one sample per tick |
| win_bits | input | WIN_W | Window length in bit periods (0 taken as 1) |
| rdata | output | 1 | Retimed data from the first flop |
| cmp_lead | output | 1 | Delayed input XOR first flop |
| cmp_dens | output | 1 | First flop XOR second flop |
| cnt_lead | output | CNT_W | Latched high-tick total of `cmp_lead` |
| cnt_dens | output | CNT_W | Latched high-tick total of `cmp_dens` |
| phase_err | output | CNT_W+2 | Signed 2*lead - density |
| res_valid | output | 1 | One-cycle pulse when new totals are latched |

## Verification
The properties assume that reset is held on the first clock edge and that `bit_en` may arrive on any pattern of ticks, including back to back. The bench drives every input on the falling edge, so each rising edge sees settled values. Reset is kept asserted through the first edges and is pulsed again during random traffic. The bench does not move `win_bits` in ways the reference model cannot follow. It changes `win_bits` only between test phases and reads the trend and saturation figures from windows opened after the change. Aligned sections keep data edges on bit boundaries as R11 requires. The random section drops that alignment on purpose, to exercise R1 to R5 with glitching data and irregular enables.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

    // Lane order inside the comparison bundle handed to the averager.
    localparam int LANE_LEAD = 0;
    localparam int LANE_DENS = 1;
    localparam int N_LANES   = 2;

    // The two comparison streams produced beside the retiming flops.
    typedef struct packed {
        logic dens;  // first flop vs second flop
        logic lead;  // delayed input vs first flop
    } cmp_pair_t;

    // Effective window length: zero is treated as a single bit period.
    function automatic int unsigned eff_window(input int unsigned w);
        return (w == 0) ? 1 : w;
    endfunction

endpackage

// File: rtl/rpd_delay_line.sv
module rpd_delay_line #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_wire
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr <= '0;
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        sr[i] <= sr[i-1];
                    end
                end
            end
            assign q = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rpd_retimer.sv
module rpd_retimer (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic d,
    output logic q1,
    output logic q2
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q1 <= 1'b0;
            q2 <= 1'b0;
        end else if (bit_en) begin
            q1 <= d;
            q2 <= q1;
        end
    end
endmodule

// File: rtl/rpd_tick_accum.sv
module rpd_tick_accum #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             close,
    output logic [CNT_W-1:0] total
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] acc_nxt;

    always_comb begin
        if (acc == CNT_MAX) acc_nxt = CNT_MAX;
        else                acc_nxt = acc + CNT_W'(hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            total <= '0;
        end else if (close) begin
            acc   <= '0;
            total <= acc_nxt;
        end else begin
            acc   <= acc_nxt;
        end
    end
endmodule

// File: rtl/rpd_window_avg.sv
module rpd_window_avg
    import rpd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WIN_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_en,
    input  logic [WIN_W-1:0]        win_bits,
    input  cmp_pair_t               cmp,
    output logic [CNT_W-1:0]        cnt_lead,
    output logic [CNT_W-1:0]        cnt_dens,
    output logic                    valid
);
    localparam int BW = WIN_W + 1;

    logic [WIN_W-1:0]          bc;
    logic [BW-1:0]             bc_inc;
    logic [BW-1:0]             win_eff;
    logic                      close;
    logic [N_LANES-1:0]        hits;
    logic [N_LANES-1:0][CNT_W-1:0] totals;

    always_comb begin
        win_eff = BW'(eff_window(int'(win_bits)));
        bc_inc  = {1'b0, bc} + BW'(1);
        close   = bit_en && (bc_inc >= win_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bc    <= '0;
            valid <= 1'b0;
        end else begin
            valid <= close;
            if (close)       bc <= '0;
            else if (bit_en) bc <= bc + WIN_W'(1);
        end
    end

    assign hits[LANE_LEAD] = cmp.lead;
    assign hits[LANE_DENS] = cmp.dens;

    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            rpd_tick_accum #(.CNT_W(CNT_W)) u_acc (
                .clk   (clk),
                .rst   (rst),
                .hit   (hits[g]),
                .close (close),
                .total (totals[g])
            );
        end
    endgenerate

    assign cnt_lead = totals[LANE_LEAD];
    assign cnt_dens = totals[LANE_DENS];
endmodule

// File: rtl/retime_phase_mon.sv
module retime_phase_mon
    import rpd_pkg::*;
#(
    parameter int DLY_STAGES = 2,
    parameter int CNT_W      = 16,
    parameter int WIN_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_en,
    input  logic                    din,
    input  logic [WIN_W-1:0]        win_bits,
    output logic                    rdata,
    output logic                    cmp_lead,
    output logic                    cmp_dens,
    output logic [CNT_W-1:0]        cnt_lead,
    output logic [CNT_W-1:0]        cnt_dens,
    output logic signed [CNT_W+1:0] phase_err,
    output logic                    res_valid
);
    localparam int EW = CNT_W + 2;

    logic      dly_q;
    logic      ret_q1;
    logic      ret_q2;
    cmp_pair_t cmp;

    rpd_delay_line #(.STAGES(DLY_STAGES)) u_dly (
        .clk (clk),
        .rst (rst),
        .d   (din),
        .q   (dly_q)
    );

    rpd_retimer u_ret (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .d      (dly_q),
        .q1     (ret_q1),
        .q2     (ret_q2)
    );

    assign cmp.lead = dly_q ^ ret_q1;
    assign cmp.dens = ret_q1 ^ ret_q2;

    rpd_window_avg #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_avg (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .win_bits (win_bits),
        .cmp      (cmp),
        .cnt_lead (cnt_lead),
        .cnt_dens (cnt_dens),
        .valid    (res_valid)
    );

    assign rdata     = ret_q1;
    assign cmp_lead  = cmp.lead;
    assign cmp_dens  = cmp.dens;
    assign phase_err = $signed({1'b0, cnt_lead, 1'b0}) - $signed(EW'(cnt_dens));
endmodule

// File: rtl/rpd_checker.sv
module rpd_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_en,
    input logic             rdata,
    input logic             q2,
    input logic             cmp_dens,
    input logic [CNT_W-1:0] cnt_lead,
    input logic [CNT_W-1:0] cnt_dens,
    input logic             res_valid
);
    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(rdata));

    // R3
    second_stage_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> (q2 == $past(rdata)));

    // R5
    dens_edge_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> (cmp_dens == (rdata != $past(rdata))));

    // R7
    totals_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !$past(rst)) |-> ($stable(cnt_lead) && $stable(cnt_dens)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && !rdata && !q2 && cnt_lead == '0 && cnt_dens == '0));
endmodule

bind retime_phase_mon rpd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .rdata     (rdata),
    .q2        (ret_q2),
    .cmp_dens  (cmp_dens),
    .cnt_lead  (cnt_lead),
    .cnt_dens  (cnt_dens),
    .res_valid (res_valid)
);

// File: tb/retime_phase_mon_bench.sv
module retime_phase_mon_bench;
    localparam int DLY  = 2;
    localparam int CW   = 10;
    localparam int WW   = 8;
    localparam int OSR  = 8;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic din = 1'b0;
    logic [WW-1:0] win_bits = WW'(32);
    logic rdata, cmp_lead, cmp_dens, res_valid;
    logic [CW-1:0] cnt_lead, cnt_dens;
    logic signed [CW+1:0] phase_err;

    retime_phase_mon #(.DLY_STAGES(DLY), .CNT_W(CW), .WIN_W(WW)) u_retime_phase_mon (
        .clk(clk), .rst(rst), .bit_en(bit_en), .din(din), .win_bits(win_bits),
        .rdata(rdata), .cmp_lead(cmp_lead), .cmp_dens(cmp_dens),
        .cnt_lead(cnt_lead), .cnt_dens(cnt_dens), .phase_err(phase_err),
        .res_valid(res_valid)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: a queue for the input delay, integers for totals.
    bit dq[$];
    bit mq1 = 0, mq2 = 0, mval = 0;
    int macc0 = 0, macc1 = 0, mcnt0 = 0, mcnt1 = 0, mbc = 0;

    initial for (int i = 0; i < DLY; i++) dq.push_back(1'b0);

    always @(posedge clk) begin
        bit dout, ha, hb, cl;
        int eff, n0, n1;
        if (rst) begin
            dq.delete();
            for (int i = 0; i < DLY; i++) dq.push_back(1'b0);
            mq1 = 0; mq2 = 0; mval = 0;
            macc0 = 0; macc1 = 0; mcnt0 = 0; mcnt1 = 0; mbc = 0;
        end else begin
            dout = dq[DLY-1];
            ha = dout ^ mq1;
            hb = mq1 ^ mq2;
            eff = (win_bits == 0) ? 1 : int'(win_bits);
            cl = bit_en && (mbc + 1 >= eff);
            n0 = (macc0 + ha > MAXC) ? MAXC : macc0 + ha;
            n1 = (macc1 + hb > MAXC) ? MAXC : macc1 + hb;
            if (cl) begin
                mcnt0 = n0; mcnt1 = n1; macc0 = 0; macc1 = 0; mbc = 0;
            end else begin
                macc0 = n0; macc1 = n1;
                if (bit_en) mbc++;
            end
            mval = cl;
            if (bit_en) begin mq2 = mq1; mq1 = dout; end
            dq.push_front(din);
            void'(dq.pop_back());
        end
    end

    // Stimulus state
    int mode = 0;
    int ph = 5;
    int tk = 0;
    int nvalid = 0;
    longint last_err = 0, last_a = 0, last_b = 0;
    bit cur_bit = 0;
    logic [14:0] lfsr = 15'h1;

    task automatic compare_all();
        chk(rdata === mq1, "R1/R2 rdata", rdata, mq1);
        chk(cmp_lead === (dq[DLY-1] ^ mq1), "R4 cmp_lead", cmp_lead, dq[DLY-1] ^ mq1);
        chk(cmp_dens === (mq1 ^ mq2), "R3/R5 cmp_dens", cmp_dens, mq1 ^ mq2);
        chk(res_valid === mval, "R7 res_valid", res_valid, mval);
        chk(int'(cnt_lead) == mcnt0, "R6/R9 cnt_lead", cnt_lead, mcnt0);
        chk(int'(cnt_dens) == mcnt1, "R6/R9 cnt_dens", cnt_dens, mcnt1);
        chk(int'(phase_err) == 2 * mcnt0 - mcnt1, "R8 phase_err", phase_err, 2 * mcnt0 - mcnt1);
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        if (res_valid) begin
            nvalid++;
            last_err = phase_err;
            last_a = cnt_lead;
            last_b = cnt_dens;
        end
        if (mode == 2) begin
            din = 1'($urandom_range(0, 1));
            bit_en = ($urandom_range(0, 9) < 3);
        end else begin
            if (tk % OSR == 0) begin
                if (mode == 0) begin
                    cur_bit = lfsr[14];
                    lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
                end else begin
                    cur_bit = ~cur_bit;
                end
            end
            din = cur_bit;
            bit_en = (tk % OSR == ph);
        end
        tk++;
    endtask

    task automatic wait_valids(input int n);
        nvalid = 0;
        while (nvalid < n) step();
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog: actual=%0d cycles expected=completion", cyc);
            finish_run();
        end
    end

    initial begin
        // R10: reset state
        repeat (3) step();
        chk(rdata == 0 && res_valid == 0, "R10 reset rdata/valid", {rdata, res_valid}, 0);
        chk(cnt_lead == 0 && cnt_dens == 0, "R10 reset totals", cnt_lead + cnt_dens, 0);
        rst = 1'b0;

        // R11: centred sampling, PRBS data, 32-bit windows
        mode = 0; ph = 5; win_bits = WW'(32);
        wait_valids(3);
        chk(last_err <= OSR && last_err >= -OSR, "R11 centred error", last_err, 0);
        chk(last_b % OSR == 0 && last_b > 0, "R11 density multiple", last_b, (last_b / OSR) * OSR);

        // R11: early sampling gives a negative error
        ph = 3;
        wait_valids(3);
        chk(last_err < 0, "R11 early sign", last_err, -1);
        chk(last_b % OSR == 0, "R11 density early", last_b, (last_b / OSR) * OSR);

        // R11: late sampling gives a positive error
        ph = 7;
        wait_valids(3);
        chk(last_err > 0, "R11 late sign", last_err, 1);

        // R6: zero window length acts as one bit
        win_bits = '0; ph = 5;
        wait_valids(2);
        nvalid = 0;
        repeat (4 * OSR) step();
        chk(nvalid == 4, "R6 zero window", nvalid, 4);

        // R6/R8: alternating data, exact totals at the centre offset
        mode = 1; ph = 5; win_bits = WW'(200);
        wait_valids(2);
        chk(last_a == 4 * 200, "R6 alternating lead total", last_a, 800);
        chk(last_b == MAXC, "R9 density saturates", last_b, MAXC);
        chk(last_err == 2 * 800 - MAXC, "R8 alternating error", last_err, 2 * 800 - MAXC);

        // R9: late offset pushes the lead total past full scale
        ph = 7;
        wait_valids(2);
        chk(last_a == MAXC, "R9 lead saturates", last_a, MAXC);

        // R1-R5 under random data and irregular enables
        mode = 2; win_bits = WW'(7);
        repeat (1500) step();

        // R10: reset in the middle of traffic
        rst = 1'b1;
        step();
        rst = 1'b0;
        mode = 0; bit_en = 1'b0;
        step();
        chk(rdata == 0 && res_valid == 0, "R10 mid-run reset", {rdata, res_valid}, 0);
        chk(cnt_lead == 0 && cnt_dens == 0 && phase_err == 0, "R10 mid-run totals", cnt_lead + cnt_dens, 0);
        repeat (20) step();

        finish_run();
    end
endmodule